// File: doc/BRIEF.md
# Self-Triggered Hit Stamping and Readout Sequencer

This block sequences the digital side of a self-triggering multi-channel front-end through three phases. During acquisition a 12-bit bunch-crossing counter advances on a slow-clock tick. Each new trigger is the OR of all channel discriminators. For each one, the current crossing number and the full channel hit pattern go into the next free slot of a 16-entry event store. When the store is full, later triggers are dropped. If an acquisition closes with nothing recorded, a no-trigger flag is raised.

A conversion command then walks the stored events in slot order and gives one strobe per event, so an external converter can digitise and write its result. A readout command shifts out, most significant bit first, the chip identifier, the event count and each stored event. A transmit-on output marks the serial bits. A one-cycle end-of-readout pulse hands control to the next chip of a daisy chain.

Top module: `hitstamp_seq`

## Requirements
- R1: After reset every output is low: acq_busy_o, mem_full_o, no_trig_o, conv_busy_o, conv_strobe_o, conv_slot_o, ser_o, tx_on_o and end_read_o.
- R2: Acquisition runs while acq_en_i is high. The crossing counter is zero at its start, advances by one on each clock with slow_tick_i high, and wraps modulo 4096.
- R3: A trigger is a clock during acquisition where the OR of ch_trig_i is high and was low on the previous clock. It stores {stamp[11:0], ch_trig_i[35:0]} in the next slot, using the stamp value before any increment on that clock. A held trigger records once.
- R4: mem_full_o is high once 16 events are stored. Triggers arriving after that are ignored until the next acquisition, which clears the store and the flag.
- R5: no_trig_o rises when an acquisition ends with zero events, and clears when the next acquisition starts.
- R6: Commands are accepted only in the idle phase, with priority acquisition, then conversion, then readout. At most one of acq_busy_o, conv_busy_o and tx_on_o is high at any time.
- R7: A conversion command with N>0 stored events holds conv_busy_o for N*CONV_CYC clocks. It gives one conv_strobe_o per event, with conv_slot_o counting up from 0. With N=0 the command is ignored.
- R8: Readout sends ser_o MSB first, one bit per clock, with tx_on_o high on exactly those clocks. The order is: chip_id_i (8 bits), the count N (5 bits), then for each event from oldest to newest the 12-bit stamp followed by the 36 hit bits.
- R9: end_read_o pulses for one clock right after the last bit. With N=0 this follows the 13 header bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_id_i | input | 8 | Identifier sent at the start of readout |
| acq_en_i | input | 1 | Acquisition window (level) |
| slow_tick_i | input | 1 | One-clock pulse per bunch crossing |
| ch_trig_i | input | 36 | Per-channel trigger discriminators |
| start_conv_i | input | 1 | Conversion command |
| start_read_i | input | 1 | Readout command / daisy-chain token in |
| acq_busy_o | output | 1 | Acquisition phase active |
| mem_full_o | output | 1 | All event slots used |
| no_trig_o | output | 1 | Last acquisition recorded no events |
| conv_busy_o | output | 1 | Conversion phase active |
| conv_strobe_o | output | 1 | Start of one event's conversion |
| conv_slot_o | output | 4 | Slot being converted |
| ser_o | output | 1 | Serial data |
| tx_on_o | output | 1 | Serial data valid |
| end_read_o | output | 1 | Readout finished / daisy-chain token out |

## Verification
Acquisitions are driven with a few sparse single-clock triggers, with triggers held over several clocks, and with an overrun of twenty back-to-back triggers. These separate edge detection, slot ordering and full-store dropping. A long run with a tick on every clock lets the stamp wrap. An acquisition with no triggers exercises the no-trigger flag and the header-only readout. Each readout stream is compared bit by bit against a stream built arithmetically from the stimulus. Conversion strobes and busy length are counted per event count. Commands issued during acquisition must leave conversion and transmit idle.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV, ST_READ} seq_st_e;
  typedef enum logic [1:0] {PH_ID, PH_CNT, PH_EVT} ser_ph_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/hs_bcid_ctr.sv
module hs_bcid_ctr #(
  parameter int BCID_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BCID_W-1:0] bcid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bcid_o <= '0;
    else if (clr_i) bcid_o <= '0;
    else if (inc_i) bcid_o <= bcid_o + 1'b1;
  end
endmodule

// File: rtl/hs_event_store.sv
module hs_event_store #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 48,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign full_o  = (cnt_o == CNT_W'(DEPTH));
  assign rdata_o = mem_q[rd_idx_i[SLOT_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (wr_i && !full_o)   cnt_o <= cnt_o + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_i && !full_o && cnt_o == CNT_W'(g)) mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/hs_conv_seq.sv
module hs_conv_seq #(
  parameter int DEPTH    = 16,
  parameter int CONV_CYC = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int TMR_W  = $clog2(CONV_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  ev_cnt_i,
  output logic              busy_o,
  output logic              strobe_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             slot_end;

  assign slot_end = busy_o && (tmr_q == TMR_W'(CONV_CYC - 1));
  assign done_o   = slot_end && (CNT_W'(slot_o) + 1'b1 == ev_cnt_i);
  assign strobe_o = busy_o && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      tmr_q  <= '0;
      slot_o <= '0;
    end else if (go_i) begin
      busy_o <= 1'b1;
      tmr_q  <= '0;
      slot_o <= '0;
    end else if (busy_o) begin
      if (done_o) begin
        busy_o <= 1'b0;
        tmr_q  <= '0;
        slot_o <= '0;
      end else if (slot_end) begin
        tmr_q  <= '0;
        slot_o <= slot_o + 1'b1;
      end else begin
        tmr_q  <= tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hs_serializer.sv
module hs_serializer
  import hs_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int CNT_W  = 5,
  parameter int WORD_W = 48,
  localparam int SH_W  = max3(ID_W, CNT_W, WORD_W),
  localparam int BIT_W = $clog2(SH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   chip_id_i,
  input  logic [CNT_W-1:0]  ev_cnt_i,
  input  logic [WORD_W-1:0] ev_word_i,
  output logic [CNT_W-1:0]  rd_idx_o,
  output logic              ser_o,
  output logic              tx_on_o,
  output logic              last_o,
  output logic              end_o
);
  ser_ph_e          ph_q;
  logic [SH_W-1:0]  sh_q;
  logic [BIT_W-1:0] left_q;
  logic             fld_end;

  assign fld_end = tx_on_o && (left_q == BIT_W'(1));
  assign ser_o   = tx_on_o && sh_q[SH_W-1];

  always_comb begin
    last_o = 1'b0;
    if (fld_end) begin
      unique case (ph_q)
        PH_CNT:  last_o = (ev_cnt_i == '0);
        PH_EVT:  last_o = (rd_idx_o == ev_cnt_i);
        default: last_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_on_o  <= 1'b0;
      ph_q     <= PH_ID;
      sh_q     <= '0;
      left_q   <= '0;
      rd_idx_o <= '0;
      end_o    <= 1'b0;
    end else begin
      end_o <= last_o;
      if (start_i) begin
        tx_on_o  <= 1'b1;
        ph_q     <= PH_ID;
        sh_q     <= SH_W'(chip_id_i) << (SH_W - ID_W);
        left_q   <= BIT_W'(ID_W);
        rd_idx_o <= '0;
      end else if (fld_end) begin
        if (last_o) begin
          tx_on_o <= 1'b0;
        end else if (ph_q == PH_ID) begin
          ph_q   <= PH_CNT;
          sh_q   <= SH_W'(ev_cnt_i) << (SH_W - CNT_W);
          left_q <= BIT_W'(CNT_W);
        end else begin
          ph_q     <= PH_EVT;
          sh_q     <= SH_W'(ev_word_i) << (SH_W - WORD_W);
          left_q   <= BIT_W'(WORD_W);
          rd_idx_o <= rd_idx_o + 1'b1;
        end
      end else if (tx_on_o) begin
        sh_q   <= sh_q << 1;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hitstamp_seq.sv
module hitstamp_seq
  import hs_pkg::*;
#(
  parameter int NUM_CH   = 36,
  parameter int DEPTH    = 16,
  parameter int BCID_W   = 12,
  parameter int ID_W     = 8,
  parameter int CONV_CYC = 4,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int WORD_W = BCID_W + NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   chip_id_i,
  input  logic              acq_en_i,
  input  logic              slow_tick_i,
  input  logic [NUM_CH-1:0] ch_trig_i,
  input  logic              start_conv_i,
  input  logic              start_read_i,
  output logic              acq_busy_o,
  output logic              mem_full_o,
  output logic              no_trig_o,
  output logic              conv_busy_o,
  output logic              conv_strobe_o,
  output logic [SLOT_W-1:0] conv_slot_o,
  output logic              ser_o,
  output logic              tx_on_o,
  output logic              end_read_o
);
  seq_st_e st_q;
  logic [BCID_W-1:0] bcid_q;
  logic [CNT_W-1:0]  ev_cnt;
  logic [CNT_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic trig_or, trig_q, rec;
  logic acq_start, acq_run, acq_stop, conv_go, read_go;
  logic conv_done, read_last;

  assign trig_or   = |ch_trig_i;
  assign acq_start = (st_q == ST_IDLE) && acq_en_i;
  assign acq_run   = (st_q == ST_ACQ) && acq_en_i;
  assign acq_stop  = (st_q == ST_ACQ) && !acq_en_i;
  assign conv_go   = (st_q == ST_IDLE) && !acq_en_i && start_conv_i && (ev_cnt != '0);
  assign read_go   = (st_q == ST_IDLE) && !acq_en_i && !conv_go && start_read_i;
  assign rec       = acq_run && trig_or && !trig_q && !mem_full_o;
  assign acq_busy_o = (st_q == ST_ACQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      trig_q    <= 1'b0;
      no_trig_o <= 1'b0;
    end else begin
      trig_q <= trig_or;
      if (acq_start)     no_trig_o <= 1'b0;
      else if (acq_stop) no_trig_o <= (ev_cnt == '0);
      unique case (st_q)
        ST_IDLE: begin
          if (acq_start)    st_q <= ST_ACQ;
          else if (conv_go) st_q <= ST_CONV;
          else if (read_go) st_q <= ST_READ;
        end
        ST_ACQ:  if (acq_stop)  st_q <= ST_IDLE;
        ST_CONV: if (conv_done) st_q <= ST_IDLE;
        ST_READ: if (read_last) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  hs_bcid_ctr #(.BCID_W(BCID_W)) u_bcid (
    .clk_i, .rst_ni,
    .clr_i (acq_start),
    .inc_i (acq_run && slow_tick_i),
    .bcid_o(bcid_q)
  );

  hs_event_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (acq_start),
    .wr_i    (rec),
    .wdata_i ({bcid_q, ch_trig_i}),
    .rd_idx_i(rd_idx),
    .rdata_o (rd_word),
    .cnt_o   (ev_cnt),
    .full_o  (mem_full_o)
  );

  hs_conv_seq #(.DEPTH(DEPTH), .CONV_CYC(CONV_CYC)) u_conv (
    .clk_i, .rst_ni,
    .go_i    (conv_go),
    .ev_cnt_i(ev_cnt),
    .busy_o  (conv_busy_o),
    .strobe_o(conv_strobe_o),
    .slot_o  (conv_slot_o),
    .done_o  (conv_done)
  );

  hs_serializer #(.ID_W(ID_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_ser (
    .clk_i, .rst_ni,
    .start_i  (read_go),
    .chip_id_i(chip_id_i),
    .ev_cnt_i (ev_cnt),
    .ev_word_i(rd_word),
    .rd_idx_o (rd_idx),
    .ser_o    (ser_o),
    .tx_on_o  (tx_on_o),
    .last_o   (read_last),
    .end_o    (end_read_o)
  );
endmodule

// File: rtl/hs_chk.sv
module hs_chk #(
  parameter int DEPTH  = 16,
  parameter int BCID_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acq_busy_o,
  input logic              mem_full_o,
  input logic              no_trig_o,
  input logic              conv_busy_o,
  input logic              conv_strobe_o,
  input logic              tx_on_o,
  input logic              end_read_o,
  input logic [CNT_W-1:0]  ev_cnt,
  input logic [BCID_W-1:0] bcid_q
);
  // R6
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acq_busy_o, conv_busy_o, tx_on_o}));
  // R2
  bcid_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acq_busy_o) |-> (bcid_q == '0));
  // R4
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_full_o && acq_busy_o) |=> $stable(ev_cnt));
  // R5
  no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_trig_o |-> (ev_cnt == '0));
  // R7
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_strobe_o |-> conv_busy_o);
  // R9
  end_after_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_on_o) |-> end_read_o);
  // R9
  end_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_read_o |=> !end_read_o);
endmodule

bind hitstamp_seq hs_chk #(.DEPTH(DEPTH), .BCID_W(BCID_W)) u_chk (.*);

// File: tb/hitstamp_seq_test.sv
module hitstamp_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 36;
  localparam int DEP = 16;
  localparam int CCYC = 4;
  localparam logic [7:0] CID = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_en = 1'b0, tick = 1'b0, s_conv = 1'b0, s_read = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic acq_busy, mem_full, no_trig, conv_busy, conv_strobe, ser, tx_on, end_read;
  logic [3:0] conv_slot;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  int m_bcid, m_cnt;
  bit m_acq, m_prev, m_notrig;
  logic [47:0] m_ev [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  hitstamp_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .chip_id_i(CID), .acq_en_i(acq_en),
    .slow_tick_i(tick), .ch_trig_i(trig), .start_conv_i(s_conv),
    .start_read_i(s_read), .acq_busy_o(acq_busy), .mem_full_o(mem_full),
    .no_trig_o(no_trig), .conv_busy_o(conv_busy), .conv_strobe_o(conv_strobe),
    .conv_slot_o(conv_slot), .ser_o(ser), .tx_on_o(tx_on), .end_read_o(end_read)
  );

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: apply inputs, advance the model, step to next negedge.
  task automatic cyc(bit a, bit t, logic [NCH-1:0] tr);
    acq_en = a; tick = t; trig = tr;
    if (!m_acq) begin
      if (a) begin m_acq = 1; m_bcid = 0; m_cnt = 0; m_notrig = 0; end
    end else if (!a) begin
      m_acq = 0; m_notrig = (m_cnt == 0);
    end else begin
      if ((|tr) && !m_prev && m_cnt < DEP) begin
        m_ev[m_cnt] = {m_bcid[11:0], tr};
        m_cnt++;
      end
      if (t) m_bcid = (m_bcid + 1) % 4096;
    end
    m_prev = |tr;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic flags(string tag);
    check({tag, " R4 full"}, mem_full, (m_cnt == DEP));
    check({tag, " R5 notrig"}, no_trig, m_notrig);
  endtask

  function automatic bit exp_bit(int k);
    int e, b;
    logic [4:0] c5;
    c5 = 5'(m_cnt);
    if (k < 8) return CID[7-k];
    if (k < 13) return c5[4-(k-8)];
    e = (k - 13) / 48;
    b = (k - 13) % 48;
    return m_ev[e][47-b];
  endfunction

  task automatic readout(string tag);
    int len, bad, txbad;
    len = 13 + 48 * m_cnt; bad = 0; txbad = 0;
    s_read = 1; @(posedge clk); @(negedge clk); s_read = 0;
    for (int k = 0; k < len; k++) begin
      if (ser !== exp_bit(k)) bad++;
      if (tx_on !== 1'b1) txbad++;
      @(posedge clk); @(negedge clk);
    end
    check({tag, " R8 stream mismatches"}, bad, 0);
    check({tag, " R8 tx_on gaps"}, txbad, 0);
    check({tag, " R8 tx_on off after last bit"}, tx_on, 0);
    check({tag, " R9 end_read pulse"}, end_read, 1);
    @(posedge clk); @(negedge clk);
    check({tag, " R9 end_read single"}, end_read, 0);
  endtask

  task automatic convert(string tag);
    int strobes, busy, slot_bad;
    strobes = 0; busy = 0; slot_bad = 0;
    s_conv = 1; @(posedge clk); @(negedge clk); s_conv = 0;
    for (int k = 0; k < DEP * CCYC + 4; k++) begin
      if (conv_busy) busy++;
      if (conv_strobe) begin
        if (conv_slot != 4'(strobes)) slot_bad++;
        strobes++;
      end
      @(posedge clk); @(negedge clk);
    end
    check({tag, " R7 strobes"}, strobes, m_cnt);
    check({tag, " R7 busy clocks"}, busy, m_cnt * CCYC);
    check({tag, " R7 slot order"}, slot_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_acq = 0; m_prev = 0; m_notrig = 0; m_cnt = 0; m_bcid = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs idle", {acq_busy, mem_full, no_trig, conv_busy, conv_strobe,
                              ser, tx_on, end_read, conv_slot}, 0);
    rst_n = 1; @(negedge clk);

    // A: sparse single-hot triggers with ticks (R2, R3)
    cyc(1, 0, '0);
    check("R6 acq_busy", acq_busy, 1);
    for (int i = 0; i < 30; i++)
      cyc(1, (i % 3) == 0, (i % 7 == 2) ? (36'h1 << (i + 5)) : '0);
    s_read = 1; s_conv = 1; cyc(1, 0, '0); s_read = 0; s_conv = 0;
    check("R6 read ignored in acq", tx_on, 0);
    check("R6 conv ignored in acq", conv_busy, 0);
    cyc(0, 0, '0);
    check("R3 events A", m_cnt, 4);
    flags("A");
    convert("A");
    readout("A R3");

    // B: held and multi-channel triggers, retrigger edge (R3)
    cyc(1, 0, '0);
    for (int i = 0; i < 12; i++)
      cyc(1, 1, (i >= 2 && i < 6) ? 36'hF_0000_000F : (i == 8 ? 36'h8_0000_0001 : '0));
    cyc(0, 0, '0);
    check("R3 held records once", m_cnt, 2);
    readout("B R3");

    // C: zero events (R5, R9)
    cyc(1, 1, '0); cyc(1, 1, '0); cyc(1, 0, '0); cyc(0, 0, '0);
    flags("C");
    convert("C R7 none");
    readout("C R9");

    // D: overrun beyond capacity (R4)
    cyc(1, 0, '0);
    for (int i = 0; i < 20; i++) begin
      cyc(1, 1, 36'(i * 37 + 1) | (36'h1 << (i + 16)));
      cyc(1, 1, '0);
    end
    flags("D in acq");
    cyc(0, 0, '0);
    flags("D");
    convert("D");
    readout("D R4");

    // E: new acquisition clears full, stamp wraps past 4096 (R2, R4, R5)
    cyc(1, 0, '0);
    check("R4 full cleared", mem_full, 0);
    check("R5 notrig cleared", no_trig, 0);
    for (int i = 0; i < 4100; i++) cyc(1, 1, '0);
    cyc(1, 0, 36'h0_0000_0100);
    cyc(1, 0, '0);
    cyc(0, 0, '0);
    check("R2 wrapped stamp", m_ev[0][47:36], 4);
    readout("E R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule